// File: doc/BRIEF.md
# Dual-Channel Simultaneous-Sampling Converter Serial Interface Model

This block is a synthesizable device-side model of the digital side of a two-channel 12-bit converter. The two channels sample at the same instant. Two signed 12-bit parallel samples arrive from elsewhere in the chip. The block watches an externally driven active-low frame select and a serial clock. It serialises the samples exactly as the converter would, so a host serial port can be exercised against realistic framing without any analog circuitry.

Both serial inputs are asynchronous to the fast system clock that runs the block. A short synchronizer chain brings them in, and their edges are detected on the system clock. Each channel word starts with four zero bits. Twelve two's-complement data bits follow, most significant first. In dual-line mode each channel has its own data line. In single-line mode both words go out one after the other on the first line, and the second line is turned off. While the frame select stays low, words repeat back to back. Raising it early abandons the word that is in progress.

Top module: `dual_sar_serial_emu`

## Requirements
- R1: Out of reset, and while the synchronized frame select is high, both output enables are low and both data outputs are 0, whatever the serial clock does.
- R2: Within a channel word, counted falling edges 1 to 4 drive 0. Falling edges 5 to 16 drive sample bits 11 down to 0, in that order.
- R3: If the frame select falls while the serial clock is low, that fall counts as falling edge 1. If the serial clock is high at that moment, edge 1 is the next serial clock fall.
- R4: Both channel inputs are captured together at falling edge 4 of every word. Changes on the sample inputs after that edge do not alter the word being shifted.
- R5: With the mode input high (1 = dual-line), channel A goes out on line A and channel B goes out on line B at the same time, and both enables are high.
- R6: With the mode input low, line A carries the channel A word followed by the channel B word over 32 falling edges. Line B's enable stays low. The mode is latched when the frame select falls, and later changes to the mode input have no effect until the next frame.
- R7: While the frame select stays low, the next falling edge after the last edge of a word (edge 16 in dual-line mode, edge 32 in single-line mode) starts a new word at edge 1. The new word captures fresh samples at its own edge 4.
- R8: Raising the frame select in mid-word drops both enables. The next fall of the frame select starts a clean word from edge 1.
- R9: The data outputs reflect a serial clock fall or a frame select fall within 4 system clock cycles of that input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sel_n | input | 1 | Active-low frame select, asynchronous |
| ser_clk | input | 1 | Serial clock, asynchronous |
| dual_mode | input | 1 | 1 = dual-line output, 0 = single-line output |
| samp_a | input | 12 | Channel A signed sample |
| samp_b | input | 12 | Channel B signed sample |
| dout_a | output | 1 | Serial data, line A |
| dout_a_oe | output | 1 | Drive enable for line A |
| dout_b | output | 1 | Serial data, line B |
| dout_b_oe | output | 1 | Drive enable for line B |

## Verification
A wrong edge position shows up at once as a sample bit moved by one or more places, or as a leading zero appearing where data should be. A position that fails to wrap corrupts the first word of a continuous run. A late or missing capture shows up as the previous word's data, or as stray post-capture input values, in the data bits after edge 4. A stuck mode or enable is visible on the enable pins within four system cycles of the frame select change that should have moved it.

// File: rtl/dsse_pkg.sv
package dsse_pkg;
  // synchronized view of one asynchronous serial-side input
  typedef struct packed {
    logic level;  // synchronized level
    logic fall;   // one-cycle pulse on a high-to-low transition
  } sync_edge_t;
endpackage

// File: rtl/dsse_edge_sync.sv
module dsse_edge_sync
  import dsse_pkg::*;
#(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       async_in,
  output sync_edge_t ev
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= RST_VAL;
    else        chain_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= RST_VAL;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= RST_VAL;
    else        last_q <= chain_q[STAGES-1];
  end

  assign ev.level = chain_q[STAGES-1];
  assign ev.fall  = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/dsse_frame_seq.sv
module dsse_frame_seq
  import dsse_pkg::*;
#(
  parameter int unsigned WORD_LEN = 16,
  parameter int unsigned CAP_POS  = 4,
  parameter int unsigned POS_W    = $clog2(2*WORD_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sync_edge_t       sel_ev,
  input  sync_edge_t       sck_ev,
  input  logic             dual_mode,
  output logic             active,
  output logic             mode_q,
  output logic [POS_W-1:0] pos,
  output logic             capture
);
  localparam logic [POS_W-1:0] LAST_DUAL   = POS_W'(WORD_LEN);
  localparam logic [POS_W-1:0] LAST_SINGLE = POS_W'(2*WORD_LEN);
  localparam logic [POS_W-1:0] CAP_AT      = POS_W'(CAP_POS);

  logic [POS_W-1:0] last_pos;
  logic [POS_W-1:0] pos_next;
  logic             advance;

  always_comb begin
    last_pos = mode_q ? LAST_DUAL : LAST_SINGLE;
    advance  = active && !sel_ev.fall && !sel_ev.level && sck_ev.fall;
    pos_next = (pos == last_pos) ? POS_W'(1) : pos + POS_W'(1);
    capture  = advance && (pos_next == CAP_AT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      mode_q <= 1'b1;
      pos    <= '0;
    end else if (sel_ev.level) begin
      active <= 1'b0;
      pos    <= '0;
    end else if (sel_ev.fall) begin
      active <= 1'b1;
      mode_q <= dual_mode;
      // clock low at frame start: the select fall is edge 1
      pos    <= sck_ev.level ? '0 : POS_W'(1);
    end else if (advance) begin
      pos <= pos_next;
    end
  end

  // R7
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= last_pos);

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && pos == last_pos) |=> (pos == POS_W'(1)));

  // R4
  capture_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (pos == CAP_AT && active));
endmodule

// File: rtl/dsse_sample_path.sv
module dsse_sample_path #(
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned NULL_W   = 4,
  parameter int unsigned WORD_LEN = NULL_W + DATA_W,
  parameter int unsigned POS_W    = $clog2(2*WORD_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              active,
  input  logic              mode_q,
  input  logic [POS_W-1:0]  pos,
  input  logic [DATA_W-1:0] samp_a,
  input  logic [DATA_W-1:0] samp_b,
  output logic              dout_a,
  output logic              dout_a_oe,
  output logic              dout_b,
  output logic              dout_b_oe
);
  localparam logic [POS_W-1:0] WLEN = POS_W'(WORD_LEN);

  logic [DATA_W-1:0] shadow_a;
  logic [DATA_W-1:0] shadow_b;

  // bit driven at word position p (1-based); 0 outside the word
  function automatic logic word_bit(input logic [POS_W-1:0] p,
                                    input logic [DATA_W-1:0] w);
    logic [WORD_LEN-1:0] full;
    logic [WORD_LEN-1:0] shifted;
    full = {{NULL_W{1'b0}}, w};
    if (p == '0 || p > WLEN) return 1'b0;
    shifted = full >> (WORD_LEN - int'(p));
    return shifted[0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_a <= '0;
      shadow_b <= '0;
    end else if (capture) begin
      shadow_a <= samp_a;
      shadow_b <= samp_b;
    end
  end

  always_comb begin
    dout_a_oe = active;
    dout_b_oe = active && mode_q;
    dout_a    = 1'b0;
    dout_b    = 1'b0;
    if (active) begin
      if (mode_q) begin
        dout_a = word_bit(pos, shadow_a);
        dout_b = word_bit(pos, shadow_b);
      end else if (pos <= WLEN) begin
        dout_a = word_bit(pos, shadow_a);
      end else begin
        dout_a = word_bit(pos - WLEN, shadow_b);
      end
    end
  end

  // R4
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(shadow_a) && $stable(shadow_b)));

  // R2
  lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pos >= POS_W'(1) && pos <= POS_W'(NULL_W)) |-> (!dout_a && !dout_b));

  // R6
  b_needs_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_b_oe |-> dout_a_oe);
endmodule

// File: rtl/dual_sar_serial_emu.sv
module dual_sar_serial_emu
  import dsse_pkg::*;
#(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned NULL_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sel_n,
  input  logic              ser_clk,
  input  logic              dual_mode,
  input  logic [DATA_W-1:0] samp_a,
  input  logic [DATA_W-1:0] samp_b,
  output logic              dout_a,
  output logic              dout_a_oe,
  output logic              dout_b,
  output logic              dout_b_oe
);
  localparam int unsigned WORD_LEN = NULL_W + DATA_W;
  localparam int unsigned POS_W    = $clog2(2*WORD_LEN + 1);

  sync_edge_t       sel_ev;
  sync_edge_t       sck_ev;
  logic             active;
  logic             mode_q;
  logic [POS_W-1:0] pos;
  logic             capture;

  dsse_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
    .clk(clk), .rst_n(rst_n), .async_in(frame_sel_n), .ev(sel_ev));

  dsse_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ser_clk), .ev(sck_ev));

  dsse_frame_seq #(.WORD_LEN(WORD_LEN), .CAP_POS(NULL_W), .POS_W(POS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .sel_ev(sel_ev), .sck_ev(sck_ev),
    .dual_mode(dual_mode), .active(active), .mode_q(mode_q),
    .pos(pos), .capture(capture));

  dsse_sample_path #(.DATA_W(DATA_W), .NULL_W(NULL_W), .WORD_LEN(WORD_LEN),
                     .POS_W(POS_W)) u_path (
    .clk(clk), .rst_n(rst_n), .capture(capture), .active(active),
    .mode_q(mode_q), .pos(pos), .samp_a(samp_a), .samp_b(samp_b),
    .dout_a(dout_a), .dout_a_oe(dout_a_oe),
    .dout_b(dout_b), .dout_b_oe(dout_b_oe));

  // R1
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ev.level |=> (!dout_a_oe && !dout_b_oe && !dout_a && !dout_b));

  // R8
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_a_oe) |-> (!dout_a && !dout_b));
endmodule

// File: tb/dual_sar_serial_emu_bench.sv
module dual_sar_serial_emu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_sel_n = 1'b1;
  logic        ser_clk = 1'b1;
  logic        dual_mode = 1'b1;
  logic [11:0] samp_a = '0;
  logic [11:0] samp_b = '0;
  logic        dout_a, dout_a_oe, dout_b, dout_b_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  dual_sar_serial_emu u_dual_sar_serial_emu (
    .clk(clk), .rst_n(rst_n), .frame_sel_n(frame_sel_n), .ser_clk(ser_clk),
    .dual_mode(dual_mode), .samp_a(samp_a), .samp_b(samp_b),
    .dout_a(dout_a), .dout_a_oe(dout_a_oe), .dout_b(dout_b), .dout_b_oe(dout_b_oe));

  typedef struct {
    string rq;
    logic  ea, eaoe, eb, eboe;
  } exp_t;

  exp_t q[$];
  event smp;

  // scoreboard monitor
  initial forever begin
    @(smp);
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (dout_a !== e.ea || dout_a_oe !== e.eaoe || dout_b !== e.eb || dout_b_oe !== e.eboe) begin
        fails++;
        $display("FAIL %s: got a=%b oe_a=%b b=%b oe_b=%b, expected a=%b oe_a=%b b=%b oe_b=%b",
                 e.rq, dout_a, dout_a_oe, dout_b, dout_b_oe, e.ea, e.eaoe, e.eb, e.eboe);
      end
    end
  end

  task automatic expect_now(input string rq, input logic ea, input logic eaoe,
                            input logic eb, input logic eboe);
    exp_t e;
    e.rq = rq; e.ea = ea; e.eaoe = eaoe; e.eb = eb; e.eboe = eboe;
    q.push_back(e);
    -> smp;
  endtask

  // expected serial bit k (1..16) of a word: four zeros, then the sample MSB first
  function automatic logic ref_bit(input int k, input logic [11:0] w);
    logic [15:0] word16;
    word16 = {4'h0, w};
    if (k < 1 || k > 16) return 1'b0;
    return word16[16-k];
  endfunction

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame: words back to back, optional abort after edge abort_at
  task automatic run_frame(input logic dual, input logic [11:0] a0, input logic [11:0] b0,
                           input logic [11:0] a1, input logic [11:0] b1,
                           input int words, input bit start_low, input int abort_at,
                           input string rq);
    int len, total, first;
    len   = dual ? 16 : 32;
    total = words * len;
    dual_mode = dual;
    samp_a = a0; samp_b = b0;
    ser_clk = start_low ? 1'b0 : 1'b1;
    wait_sys(8);
    frame_sel_n = 1'b0;
    wait_sys(4);
    expect_now({rq, " frame start"}, 1'b0, 1'b1, 1'b0, dual);
    dual_mode = ~dual;  // must be ignored until the next frame (R6)
    first = start_low ? 2 : 1;
    for (int e = first; e <= total; e++) begin
      int w, p;
      logic [11:0] wa, wb;
      logic ea, eb;
      w  = (e - 1) / len;
      p  = (e - 1) % len + 1;
      wa = (w == 0) ? a0 : a1;
      wb = (w == 0) ? b0 : b1;
      ser_clk = 1'b1;
      wait_sys(6);
      ser_clk = 1'b0;
      wait_sys(4);
      if (dual) begin
        ea = ref_bit(p, wa);
        eb = ref_bit(p, wb);
      end else begin
        ea = (p <= 16) ? ref_bit(p, wa) : ref_bit(p - 16, wb);
        eb = 1'b0;
      end
      expect_now($sformatf("%s edge %0d", rq, e), ea, 1'b1, eb, dual);
      if (p == 4) begin
        samp_a = (w == 0) ? a1 : ~a1;
        samp_b = (w == 0) ? b1 : ~b1;
      end
      wait_sys(4);
      if (e == abort_at) break;
    end
    ser_clk = 1'b1;
    wait_sys(6);
    frame_sel_n = 1'b1;
    wait_sys(4);
    expect_now({rq, " frame end R1 R8"}, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no finish, expected finish before timeout");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_sys(5);
    // R1: reset state
    expect_now("R1 reset", 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    wait_sys(4);
    // R1: serial clock toggling while frame select is high
    for (int i = 0; i < 3; i++) begin
      ser_clk = 1'b0; wait_sys(6);
      expect_now("R1 idle toggle", 1'b0, 1'b0, 1'b0, 1'b0);
      ser_clk = 1'b1; wait_sys(6);
    end
    // R2 R5 R9 R3: dual-line, clock high at frame start
    run_frame(1'b1, 12'h5A3, 12'hA5C, 12'h0FF, 12'hF00, 1, 1'b0, 0, "R2 R5 R9 R3 dual");
    // R3: dual-line, clock low at frame start; full-scale codes
    run_frame(1'b1, 12'h7FF, 12'h800, 12'h000, 12'hFFF, 1, 1'b1, 0, "R3 low start");
    // R6: single-line, A then B on line A
    run_frame(1'b0, 12'h123, 12'hED4, 12'h555, 12'hAAA, 1, 1'b0, 0, "R6 single");
    // R6 R3: single-line with clock low at frame start
    run_frame(1'b0, 12'h9B6, 12'h24D, 12'h3C3, 12'hC3C, 1, 1'b1, 0, "R6 R3 single low");
    // R7 R4: continuous dual-line, fresh capture in the second word
    run_frame(1'b1, 12'h3C1, 12'h0F0, 12'h8E7, 12'h71A, 2, 1'b0, 0, "R7 R4 continuous");
    // R7: continuous single-line
    run_frame(1'b0, 12'h6A9, 12'h951, 12'h1E2, 12'hE1D, 2, 1'b0, 0, "R7 single continuous");
    // R8: abort after edge 9, then a clean frame
    run_frame(1'b1, 12'hB2E, 12'h4D1, 12'h111, 12'h222, 1, 1'b0, 9, "R8 abort");
    run_frame(1'b1, 12'h2C7, 12'hD38, 12'h333, 12'h444, 1, 1'b0, 0, "R8 after abort");
    wait_sys(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule